// File: doc/BRIEF.md
# Bit-Serial Running Maximum

This block tracks the largest of a stream of unsigned words that arrive one bit per clock, most significant bit first. The largest value seen so far sits in a W-bit shift register that rotates in lockstep with the incoming bits. A three-state comparator looks at each incoming bit together with the stored bit at the register head. It picks the bit of whichever word is larger and sends that bit both to the serial output and back into the register tail. A stream of N words therefore costs W×N clocks, and the storage is the register plus two comparator bits.

A word begins with a one-cycle `word_start` pulse on its first (top) bit. Back-to-back words put the next pulse exactly W cycles later. If no pulse comes, the block idles and holds its maximum. While a word streams in, `dout` carries the matching bit of max(previous maximum, current word) in the same cycle, so the last bit of a word completes the updated maximum. A synchronous `clear` zeroes the stored maximum and abandons any word in progress, so the next word is taken as the maximum unchanged.

Top module: `bitser_max`

## Requirements
- R1: After reset or `clear` the stored maximum is zero, and while no word is in progress `dout` and `word_done` are 0.
- R2: The first complete word after reset or `clear` appears on `dout` unchanged, bit for bit, in the same cycles as its input bits.
- R3: During every word, `dout` carries max(all words completed since the last clear, current word), most significant bit first, with each output bit in the same cycle as the input bit of the same weight.
- R4: When the stored maximum is larger, `dout` keeps following the stored value after the first differing bit, even where the input later has ones that the stored value lacks.
- R5: A word equal to the stored maximum leaves the maximum unchanged and is output as that value.
- R6: `word_done` is 1 exactly in the cycle of the W-th bit of a word, with the `word_start` cycle counted as the first, and 0 in every other cycle.
- R7: When `word_start` does not follow the last bit of a word, the block idles. `dout` and `word_done` stay 0, the input bits are ignored, and the maximum is kept for the next word.
- R8: A `clear` during a word abandons that word. The word's bits never enter the maximum, and `clear` takes priority over a `word_start` in the same cycle.
- R9: Words may follow each other with no gap, a new `word_start` arriving in the cycle right after the previous word's last bit. Each word is compared with the maximum that includes its predecessor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the stored maximum; aborts a word in progress |
| word_start | input | 1 | Marks the cycle carrying the top bit of a word |
| din | input | 1 | Serial input word bit, most significant first |
| dout | output | 1 | Serial running-maximum bit, same cycle as `din` |
| word_done | output | 1 | High on the last bit of each word |

## Verification
The bench goes after the comparator's decision point. One test uses a word that loses on its top bit but carries ones in every lower bit. A design that let later input ones leak through would output an OR of the two words. Equal words check that a design which treats a tie as a loss or a win still reproduces the value. Idle gaps between words would expose a register that keeps rotating with no word present, which would leave the maximum misaligned on the next word. A clear in mid-word would expose a design that lets the partial word's upper bits survive into the register. Back-to-back words and a long pseudo-random sequence check that the comparator returns to the equal state at every boundary. A design that kept the previous verdict would copy the wrong side.

// File: rtl/bitser_max.sv
module bitser_max #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic word_start,
  input  logic din,
  output logic dout,
  output logic word_done
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {CMP_EQ, CMP_IN, CMP_ST} cmp_t;

  logic [W-1:0]  best_q;
  logic [CW-1:0] pos_q;
  logic          run_q;
  cmp_t          cmp_q;

  logic          active;
  logic [CW-1:0] pos;
  cmp_t          cmp;
  logic          st_bit;
  logic          pick;

  assign active = !clear && (word_start || run_q);
  assign pos    = word_start ? '0 : pos_q;
  assign cmp    = word_start ? CMP_EQ : cmp_q;
  assign st_bit = best_q[W-1];

  always_comb begin
    case (cmp)
      CMP_IN:  pick = din;
      CMP_ST:  pick = st_bit;
      default: pick = din | st_bit;
    endcase
  end

  assign dout      = active & pick;
  assign word_done = active && (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q <= '0;
      pos_q  <= '0;
      run_q  <= 1'b0;
      cmp_q  <= CMP_EQ;
    end else if (clear) begin
      best_q <= '0;
      pos_q  <= '0;
      run_q  <= 1'b0;
      cmp_q  <= CMP_EQ;
    end else if (active) begin
      best_q <= {best_q[W-2:0], pick};
      pos_q  <= pos + 1'b1;
      run_q  <= (pos != LAST);
      if (cmp == CMP_EQ && din != st_bit)
        cmp_q <= din ? CMP_IN : CMP_ST;
      else
        cmp_q <= cmp;
    end
  end

endmodule

// File: rtl/bitser_max_chk.sv
module bitser_max_chk #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic clear,
  input logic word_start,
  input logic din,
  input logic dout,
  input logic word_done
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] c_pos_q;
  logic          c_run_q;
  logic          fresh_q;
  logic          in_w;
  logic [CW-1:0] c_pos;

  assign in_w  = !clear && (word_start || c_run_q);
  assign c_pos = word_start ? '0 : c_pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_pos_q <= '0;
      c_run_q <= 1'b0;
      fresh_q <= 1'b1;
    end else if (clear) begin
      c_pos_q <= '0;
      c_run_q <= 1'b0;
      fresh_q <= 1'b1;
    end else if (in_w) begin
      c_pos_q <= c_pos + 1'b1;
      c_run_q <= (c_pos != LAST);
      if (c_pos == LAST) fresh_q <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_w |-> (!dout && !word_done)); // R7

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word_start || (!dout && !word_done))); // R8

  AST_DONE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    in_w |-> (word_done == (c_pos == LAST))); // R6

  AST_FIRST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_w && fresh_q) |-> (dout == din)); // R2

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && !clear) |-> !c_run_q); // R9

endmodule

bind bitser_max bitser_max_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .word_start(word_start),
  .din(din), .dout(dout), .word_done(word_done)
);

// File: tb/bitser_max_test.sv
module bitser_max_test;
  localparam int W = 8;
  localparam time HALF = 4ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic word_start = 1'b0;
  logic din = 1'b0;
  logic dout, word_done;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_max = '0;

  always #HALF clk = ~clk;

  bitser_max #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .word_start(word_start),
    .din(din), .dout(dout), .word_done(word_done)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_word(input string req, input logic [W-1:0] w);
    logic [W-1:0] got = '0;
    logic [W-1:0] dn  = '0;
    logic [W-1:0] e;
    e = (w > exp_max) ? w : exp_max;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      word_start = (i == 0);
      din = w[W-1-i];
      #1;
      got[W-1-i] = dout;
      dn[W-1-i]  = word_done;
    end
    exp_max = e;
    check(req, got, e);
    check("R6", dn, {{(W-1){1'b0}}, 1'b1});
  endtask

  task automatic idle(input int n);
    logic [1:0] seen = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word_start = 1'b0;
      din = i[0] | 1'b1;
      #1;
      seen = seen | {dout, word_done};
    end
    check("R7", {{(W-2){1'b0}}, seen}, '0);
  endtask

  task automatic do_clear;
    @(negedge clk);
    clear = 1'b1;
    word_start = 1'b1;
    din = 1'b1;
    #1;
    check("R1", {{(W-2){1'b0}}, dout, word_done}, '0);
    @(negedge clk);
    clear = 1'b0;
    word_start = 1'b0;
    exp_max = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R1", {{(W-2){1'b0}}, dout, word_done}, '0);
    idle(3);
  endtask

  task automatic t_basic;
    send_word("R2", 8'hA5);
    send_word("R3", 8'hC3);
    send_word("R4", 8'h5F);
    send_word("R4", 8'hBF);
    send_word("R5", 8'hC3);
  endtask

  task automatic t_gap;
    idle(5);
    send_word("R7", 8'h01);
    idle(2);
    send_word("R7", 8'hC4);
  endtask

  task automatic t_back_to_back;
    do_clear();
    send_word("R2", 8'h10);
    send_word("R9", 8'hFF);
    send_word("R9", 8'h00);
    send_word("R9", 8'hFE);
  endtask

  task automatic t_abort;
    do_clear();
    send_word("R2", 8'h0F);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      word_start = (i == 0);
      din = 1'b1;
    end
    @(negedge clk);
    word_start = 1'b0;
    clear = 1'b1;
    #1;
    check("R8", {{(W-2){1'b0}}, dout, word_done}, '0);
    @(negedge clk);
    clear = 1'b0;
    exp_max = '0;
    idle(2);
    send_word("R8", 8'h22);
  endtask

  task automatic t_random;
    logic [W-1:0] lf = 8'h5A;
    do_clear();
    for (int k = 0; k < 24; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      send_word("R3", lf);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_gap();
    t_back_to_back();
    t_abort();
    t_random();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule